// File: doc/BRIEF.md
# Byte-Parallel LFSR Noise Generator

This block is a 16-bit maximal-length linear feedback shift register. It takes eight single-bit steps in each clock, so every advance produces a new byte of pseudo-random data. Successive bytes are not simple shifted copies of each other. This makes the output fit for noise sources such as random audio samples or dither and bi-level noise patterns.

On each advance, the register moves its low byte into the high byte and drops the old high byte. It then fills the low byte with eight fresh bits, all computed in parallel from four shifted views of the current state. A seed can be loaded at any time. A seed of all zeros is replaced by a safe non-zero value, so the register never enters its lock-up state.

Top module: `lfsr_byte_noise`

## Requirements
- R1: After a synchronous reset, the state is 16'h0001, `dataOut` is 8'h01 and `dataValid` is low.
- R2: An advance without a load moves old state bits [7:0] into state bits [15:8] in the next cycle. The old bits [15:8] are discarded.
- R3: On an advance, bit i (0..7) of the new low byte equals old state bits [i+3] ^ [i+4] ^ [i+5] ^ [i+8]. Two examples: seed 16'h0008 becomes 16'h0801, and seed 16'h0100 becomes 16'h0039.
- R4: `dataOut` always equals state bits [7:0]. `dataValid` is high for exactly the one cycle after each cycle in which an advance took effect, and low otherwise.
- R5: A load sets the state to `seedIn` in the next cycle. A seed of 16'h0000 is replaced by 16'h0001.
- R6: When load and advance are asserted in the same cycle, only the load takes effect. No advance happens and `dataValid` stays low in the next cycle.
- R7: With neither load nor advance asserted, the state holds its value.
- R8: The state is never 16'h0000. From any non-zero seed, it returns to that seed after exactly 65535 advances.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| advEn | input | 1 | Advance the register by one byte (eight steps) |
| seedIn | input | 16 | Seed value for a load |
| seedLoad | input | 1 | Load strobe for `seedIn`; overrides `advEn` |
| stateOut | output | 16 | Current register state |
| dataOut | output | 8 | Current output byte (low byte of the state) |
| dataValid | output | 1 | High for one cycle after each advance |

## Verification
The bench builds the block with its default parameters: a 16-bit state, an 8-bit output and feedback taps 3, 4, 5 and 8. With these defaults, a full period of 65535 byte-steps fits in a single run, so the return-to-seed count can be measured exactly rather than inferred. The small state width also means that directed seeds with a single bit set give feedback bytes that can be worked out by hand. The bench checks these alongside random mixes of load, advance and idle cycles.

// File: rtl/lfsr_pkg.sv
package lfsr_pkg;
  // Strobes from the control to the datapath; at most one is set.
  typedef struct packed {
    logic load;
    logic step;
  } lfsrStrobes_t;
endpackage

// File: rtl/lfsr_ctrl.sv
module lfsr_ctrl
  import lfsr_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         advEn,
  input  logic         seedLoad,
  output lfsrStrobes_t strobes,
  output logic         dataValid
);
  // Load wins over advance.
  always_comb begin
    strobes.load = seedLoad;
    strobes.step = advEn & ~seedLoad;
  end

  always_ff @(posedge clk) begin
    if (rst) dataValid <= 1'b0;
    else     dataValid <= strobes.step;
  end

  // R4: an effective advance yields valid in the next cycle
  a_r4_valid_after_step: assert property (@(posedge clk) disable iff (rst)
    (advEn && !seedLoad) |=> dataValid);
  // R6: a load never produces valid, even with advance asserted
  a_r6_load_no_valid: assert property (@(posedge clk) disable iff (rst)
    seedLoad |=> !dataValid);
  // R4: no advance means no valid
  a_r4_idle_no_valid: assert property (@(posedge clk) disable iff (rst)
    !advEn |=> !dataValid);
endmodule

// File: rtl/lfsr_datapath.sv
module lfsr_datapath
  import lfsr_pkg::*;
#(
  parameter int unsigned STATE_W = 16,
  parameter int unsigned OUT_W   = 8,
  parameter int unsigned TAP_A   = 3,
  parameter int unsigned TAP_B   = 4,
  parameter int unsigned TAP_C   = 5,
  parameter int unsigned TAP_D   = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  lfsrStrobes_t       strobes,
  input  logic [STATE_W-1:0] seedIn,
  output logic [STATE_W-1:0] stateQ
);
  localparam int unsigned KEEP_W = STATE_W - OUT_W;
  localparam logic [STATE_W-1:0] SAFE_SEED = STATE_W'(1);

  logic [OUT_W-1:0]   freshByte;
  logic [STATE_W-1:0] stepped;
  logic [STATE_W-1:0] loadVal;

  // Balanced two-level XOR tree for each new bit.
  for (genvar i = 0; i < OUT_W; i++) begin : g_fb
    logic pairLo, pairHi;
    assign pairLo       = stateQ[i+TAP_A] ^ stateQ[i+TAP_B];
    assign pairHi       = stateQ[i+TAP_C] ^ stateQ[i+TAP_D];
    assign freshByte[i] = pairLo ^ pairHi;
  end

  assign stepped = {stateQ[KEEP_W-1:0], freshByte};
  assign loadVal = (seedIn == '0) ? SAFE_SEED : seedIn;

  always_ff @(posedge clk) begin
    if (rst)               stateQ <= SAFE_SEED;
    else if (strobes.load) stateQ <= loadVal;
    else if (strobes.step) stateQ <= stepped;
  end

  // R2: the old low byte moves up on a step
  a_r2_byte_shift: assert property (@(posedge clk) disable iff (rst)
    strobes.step |=> stateOut_hi_matches($past(stateQ[OUT_W-1:0])));
  // R5: a load lands the seed, or the safe value for a zero seed
  a_r5_load_value: assert property (@(posedge clk) disable iff (rst)
    (strobes.load && seedIn != '0) |=> stateQ == $past(seedIn));
  a_r5_zero_seed: assert property (@(posedge clk) disable iff (rst)
    (strobes.load && seedIn == '0) |=> stateQ == SAFE_SEED);
  // R7: idle cycles leave the state alone
  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    (!strobes.load && !strobes.step) |=> $stable(stateQ));
  // R8: lock-up state never reached
  a_r8_no_lockup: assert property (@(posedge clk) disable iff (rst)
    stateQ != '0);

  function automatic logic stateOut_hi_matches(input logic [OUT_W-1:0] prevLo);
    return stateQ[STATE_W-1 -: OUT_W] == prevLo;
  endfunction
endmodule

// File: rtl/lfsr_byte_noise.sv
module lfsr_byte_noise
  import lfsr_pkg::*;
#(
  parameter int unsigned STATE_W = 16,
  parameter int unsigned OUT_W   = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               advEn,
  input  logic [STATE_W-1:0] seedIn,
  input  logic               seedLoad,
  output logic [STATE_W-1:0] stateOut,
  output logic [OUT_W-1:0]   dataOut,
  output logic               dataValid
);
  lfsrStrobes_t strobes;

  lfsr_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .advEn     (advEn),
    .seedLoad  (seedLoad),
    .strobes   (strobes),
    .dataValid (dataValid)
  );

  lfsr_datapath #(
    .STATE_W (STATE_W),
    .OUT_W   (OUT_W)
  ) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .seedIn  (seedIn),
    .stateQ  (stateOut)
  );

  assign dataOut = stateOut[OUT_W-1:0];
endmodule

// File: tb/lfsr_byte_noise_tb.sv
`timescale 1ns/1ps
module lfsr_byte_noise_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        advEn = 1'b0;
  logic        seedLoad = 1'b0;
  logic [15:0] seedIn = '0;
  logic [15:0] stateOut;
  logic [7:0]  dataOut;
  logic        dataValid;

  int          nChecks = 0;
  int          nFails  = 0;
  bit          finished = 1'b0;
  logic [15:0] model = 16'h0001;
  logic        expValid = 1'b0;

  always #2 clk = ~clk;

  lfsr_byte_noise u_dut (
    .clk(clk), .rst(rst), .advEn(advEn), .seedIn(seedIn),
    .seedLoad(seedLoad), .stateOut(stateOut), .dataOut(dataOut),
    .dataValid(dataValid)
  );

  function automatic logic [15:0] byteStep(input logic [15:0] s);
    logic [7:0] nb;
    for (int i = 0; i < 8; i++) nb[i] = s[i+3] ^ s[i+4] ^ s[i+5] ^ s[i+8];
    return {s[7:0], nb};
  endfunction

  task automatic check(input string req, input logic [24:0] act, input logic [24:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: got state=%h data=%h valid=%b, expected state=%h data=%h valid=%b",
               req, act[24:9], act[8:1], act[0], exp[24:9], exp[8:1], exp[0]);
    end
  endtask

  // Drive at negedge, sample 1 ns after the following posedge.
  task automatic cyc(input logic adv, input logic ld, input logic [15:0] sd, input string req);
    @(negedge clk);
    advEn = adv; seedLoad = ld; seedIn = sd;
    @(posedge clk); #1;
    if (ld) begin model = (sd == 16'h0) ? 16'h0001 : sd; expValid = 1'b0; end
    else if (adv) begin model = byteStep(model); expValid = 1'b1; end
    else expValid = 1'b0;
    check(req, {stateOut, dataOut, dataValid}, {model, model[7:0], expValid});
  endtask

  initial begin
    #(4.0 * 200000);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog: got running, expected done");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    int unsigned r;
    int          cnt;
    logic [15:0] startSeed;
    r = $urandom(32'd4242);
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check("R1", {stateOut, dataOut, dataValid}, {16'h0001, 8'h01, 1'b0});
    @(negedge clk); rst = 1'b0;

    // R3 hand-worked feedback bytes, R2 byte shift
    cyc(1'b0, 1'b1, 16'h0008, "R5");
    cyc(1'b1, 1'b0, 16'h0, "R3");
    check("R3", {16'(stateOut), 9'h0}, {16'h0801, 9'h0});
    cyc(1'b0, 1'b1, 16'h0100, "R5");
    cyc(1'b1, 1'b0, 16'h0, "R2");
    check("R3", {16'(stateOut), 9'h0}, {16'h0039, 9'h0});
    // R4 valid drops after one cycle
    cyc(1'b0, 1'b0, 16'h0, "R4");
    // R7 hold
    cyc(1'b0, 1'b0, 16'hFFFF, "R7");
    // R5 zero seed replaced
    cyc(1'b0, 1'b1, 16'h0000, "R5");
    // R6 load beats advance
    cyc(1'b1, 1'b1, 16'hBEEF, "R6");
    cyc(1'b1, 1'b1, 16'h0000, "R6");

    // Random mix
    for (int k = 0; k < 3000; k++) begin
      r = $urandom;
      cyc(r[3:0] != 0, r[7:4] == 0, r[23:8] & {16{r[24]}}, "R4");
    end

    // R8 period from a chosen seed
    startSeed = 16'hACE1;
    cyc(1'b0, 1'b1, startSeed, "R5");
    cnt = 0;
    do begin
      cyc(1'b1, 1'b0, 16'h0, "R8");
      cnt++;
      if (stateOut == 16'h0) check("R8", 25'h0, 25'h1);
    end while (stateOut != startSeed && cnt < 70000);
    check("R8", 25'(cnt), 25'(65535));

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule